// File: doc/BRIEF.md
# Error-Output Feedback First-Order Delta-Sigma Stage

This block is a single first-order digital delta-sigma stage for the divider controller of a fractional-N synthesizer. On every enabled clock it adds an unsigned fractional word to two state terms: the error word kept from the previous cycle, and the previous one-bit output, which is added back as a plain 0 or 1 with no gain. When the sum reaches the modulus 2^WIDTH, the stage emits a carry and keeps the remainder as its new error word.

Both the carry and the error word come straight from registers. The error word can therefore be wired directly into the input of a following stage of a cascade. A synchronous reset puts the stage into a known all-zero state, and a low enable freezes it.

Top module: `eofm_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, `carryOut` and `errOut` are both 0 after that edge, whatever `en` and `fracIn` are.
- R2: At an enabled edge, `carryOut` becomes 1 exactly when `fracIn + errOut + carryOut`, all taken before the edge, is at least 2^WIDTH. Otherwise it becomes 0.
- R3: At an enabled edge, `errOut` becomes that same sum minus 2^WIDTH times the new `carryOut`, so it always lies in 0..2^WIDTH-1.
- R4: The previous carry is added with a weight of exactly one. From the state carry=1 and error=0, an input of 0 gives error 1 and carry 0.
- R5: While `en` is low and `rst` is low, `carryOut` and `errOut` keep their values for any `fracIn`.
- R6: The sum is formed without wrap-around. The largest sum the stage can reach is 2^(WIDTH+1)-2. It must give carry 1 and error 2^WIDTH-2.
- R7: With a constant input x over L enabled cycles after reset, the number of carries C satisfies |(2^WIDTH-1)·C − L·x| ≤ 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable, active high |
| fracIn | input | WIDTH | Unsigned fractional input word |
| carryOut | output | 1 | Registered one-bit quantizer output |
| errOut | output | WIDTH | Registered error word, fed to the next stage |

## Verification
The stage has a single register level. The carry and the error word that result from an input driven before an edge appear on the ports just after that edge. The bench drives each input on the falling edge and samples two time units after the next rising edge. At that point it compares the outputs with an arithmetic model that it updates once per edge. For a frozen or reset cycle, the comparison in the same slot checks that the outputs held their values or cleared. The carry-density bound is checked once each constant-input run has finished.

// File: rtl/eofm_pkg.sv
package eofm_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic clear;    // force the state to zero
    logic advance;  // take one modulator step
  } stageStrobe_t;

endpackage

// File: rtl/eofm_ctrl.sv
module eofm_ctrl
  import eofm_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output stageStrobe_t strobe
);

  // Reset has priority over enable.
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = en && !rst;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) $onehot0({strobe.clear, strobe.advance}))
    else $error("clear and advance strobes active together");

endmodule

// File: rtl/eofm_datapath.sv
module eofm_datapath
  import eofm_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  stageStrobe_t     strobe,
  input  logic [WIDTH-1:0] fracIn,
  output logic             carryOut,
  output logic [WIDTH-1:0] errOut
);

  localparam int SUM_W = WIDTH + 1;
  localparam int CHK_W = WIDTH + 2;
  localparam logic [CHK_W-1:0] MODULUS = CHK_W'(1) << WIDTH;

  logic [WIDTH-1:0] errReg;
  logic             carryReg;
  logic [SUM_W-1:0] sumW;
  logic             carryNext;
  logic [WIDTH-1:0] errNext;

  // Adder one bit wider than the operands: the sum never wraps.
  always_comb begin
    sumW = {1'b0, fracIn} + {1'b0, errReg} + {{WIDTH{1'b0}}, carryReg};
  end

  // Quantizer: the top bit is the carry and the low bits are the remainder.
  always_comb begin
    carryNext = sumW[SUM_W-1];
    errNext   = sumW[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      errReg   <= '0;
      carryReg <= 1'b0;
    end else if (strobe.advance) begin
      errReg   <= errNext;
      carryReg <= carryNext;
    end
  end

  assign carryOut = carryReg;
  assign errOut   = errReg;

  // Widened copies used only by the checks.
  logic [CHK_W-1:0] chkIn;
  logic [CHK_W-1:0] chkRecon;
  always_comb begin
    chkIn    = CHK_W'(fracIn) + CHK_W'(errReg) + CHK_W'(carryReg);
    chkRecon = (carryReg ? MODULUS : '0) + CHK_W'(errReg);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (carryReg == 1'b0 && errReg == '0))
    else $error("state not cleared by reset");

  // R2
  carry_thresh_chk: assert property (@(posedge clk) disable iff (rst)
      strobe.advance |=> (carryReg == ($past(chkIn) >= MODULUS)))
    else $error("carry does not match the threshold");

  // R3
  err_balance_chk: assert property (@(posedge clk) disable iff (rst)
      strobe.advance |=> (chkRecon == $past(chkIn)))
    else $error("carry and error do not rebuild the sum");

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
      !strobe.advance |=> ($stable(errReg) && $stable(carryReg)))
    else $error("state moved while not enabled");

endmodule

// File: rtl/eofm_stage.sv
module eofm_stage
  import eofm_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] fracIn,
  output logic             carryOut,
  output logic [WIDTH-1:0] errOut
);

  stageStrobe_t strobe;

  eofm_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .strobe (strobe)
  );

  eofm_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .fracIn   (fracIn),
    .carryOut (carryOut),
    .errOut   (errOut)
  );

endmodule

// File: tb/test_eofm_stage.sv
module test_eofm_stage;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] fracIn = '0;
  logic         carryOut;
  logic [W-1:0] errOut;

  int nRun  = 0;
  int nFail = 0;
  int mE = 0;
  int mY = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  eofm_stage #(.WIDTH(W)) i_eofm_stage (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .fracIn   (fracIn),
    .carryOut (carryOut),
    .errOut   (errOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, update the model at the rising edge,
  // then sample 2 time units later.
  task automatic step(input bit r, input bit e, input int x, input string tag);
    int s;
    @(negedge clk);
    rst = r; en = e; fracIn = W'(x);
    @(posedge clk);
    if (r) begin
      mE = 0; mY = 0;
    end else if (e) begin
      s  = x + mE + mY;
      mY = (s >= M) ? 1 : 0;
      mE = s - M * mY;
    end
    #2;
    check({tag, " carry"}, int'(carryOut), mY);
    check({tag, " error"}, int'(errOut), mE);
  endtask

  initial begin
    int lfsr;
    int cnt;
    int dev;
    // R1 reset state
    step(1, 0, 0, "R1");
    step(1, 1, 9, "R1");

    // R2 R3 R7: sweep every constant input
    for (int x = 0; x < M; x++) begin
      step(1, 0, 0, "R1");
      cnt = 0;
      for (int k = 0; k < 60; k++) begin
        step(0, 1, x, "R2/R3");
        cnt += int'(carryOut);
      end
      dev = (M - 1) * cnt - 60 * x;
      if (dev < 0) dev = -dev;
      check("R7 density bound", int'(dev <= M), 1);
    end

    // R4: unit-weight feedback of the carry
    step(1, 0, 0, "R1");
    step(0, 1, M - 1, "R4 setup");
    step(0, 1, 1, "R4 setup");          // sum 16: carry 1, error 0
    step(0, 1, 0, "R4");                // sum 0+0+1
    check("R4 error after carry", int'(errOut), 1);

    // R6: largest reachable sum 30
    step(1, 0, 0, "R1");
    step(0, 1, M - 1, "R6 setup");      // error 15, carry 0
    step(0, 1, M - 1, "R6");            // sum 30
    check("R6 carry", int'(carryOut), 1);
    check("R6 error", int'(errOut), M - 2);

    // R5: freeze with a moving input
    step(0, 1, 7, "R2/R3");
    for (int k = 0; k < 6; k++) step(0, 0, (k * 5 + 3) % M, "R5 hold");
    step(0, 1, 11, "R2/R3");

    // Mixed traffic with random enable and a reset in the middle
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
      if (k == 200) step(1, 1, lfsr % M, "R1 mid-run");
      else step(0, ((lfsr >> 5) & 3) != 0, lfsr % M, "R2/R3/R5 mixed");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule